// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire serial management interface that a MAC uses to reach PHY registers. Software packs a complete management frame (start code, opcode, PHY address, register address, turnaround and 16 data bits) into one 32-bit frame register. Writing that register launches exactly one read or write transaction. The block divides the system clock down to the management clock MDC using a programmable speed value. It sends a 32-bit all-ones preamble and then the frame, most significant bit first, on the MDIO output. For a read it releases the line at the turnaround and shifts in the 16 bits the PHY returns.

When the transaction ends, a done bit in the event register is set and can raise an interrupt through a mask register. Software clears the done bit by writing a one to it. For a read, the returned data replaces the low half of the frame register. The speed value should be set to the system clock in MHz divided by 5, plus 1, which keeps MDC at or below about 2.5 MHz.

Top module: `mdio_mgmt_master`

Register map (word index on `bus_addr`): 0 = frame, 1 = speed (bits [5:0]), 2 = event (bit 0 done, write 1 to clear; bit 1 busy, read only), 3 = mask (bit 0 interrupt enable). Other bits read as zero.

## Requirements
- R1: After reset, MDC and MDIO enable are low, irq is low, and the frame, speed, event and mask registers all read 0.
- R2: A write to the frame register while idle with a non-zero speed value S starts a transaction: busy reads 1 from the next cycle, and MDC toggles every S system clocks, starting low (period 2*S).
- R3: The serial stream is 64 bits: 32 preamble bits at 1, then frame bits 31 down to 0. Each bit changes only together with an MDC falling edge, so MDIO is stable at every MDC rising edge.
- R4: When frame bits [29:28] equal 2'b10 (read), MDIO enable is high for the first 46 bits and low for the last 18 (turnaround and data). For any other opcode, MDIO enable is high for all 64 bits.
- R5: For a read, MDIO input is sampled on the MDC rising edge of each of the last 16 bits, first sample as bit 15. At completion these bits replace frame register bits [15:0]; bits [31:16] keep the written value. For a write, the frame register keeps the written value.
- R6: The transaction ends at the MDC falling edge after the 64th bit. At that edge, busy clears and event bit 0 sets; MDC stays low afterwards.
- R7: Writing event bit 0 as 1 clears it. Writing it as 0 leaves it set.
- R8: irq equals event bit 0 AND mask bit 0. Event bit 0 sets whether or not the mask bit is set.
- R9: A frame register write during a transaction is ignored. The frame register keeps its value and the serial stream in progress is unchanged.
- R10: With the speed value at 0, a frame register write starts nothing: busy stays 0, MDC never toggles, and the frame register is unchanged.
- R11: While idle, MDC and MDIO enable are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt: done event and its enable |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data in |

## Verification
The bench models a PHY that records MDIO at every MDC rising edge and drives read data after falling edges. It compares each recorded bit and enable against the packed frame. A shifter off by one bit, or one that releases the line at the wrong point, would show mismatched stream bits. It also checks the enable pattern across the read turnaround. It measures every MDC half period against the speed value, including the one-clock case, where a divider compare off by one would stretch or shorten halves. Three more directed cases follow. A second frame write in mid-transaction would corrupt the stream or the frame register if accepted. A zero speed value would start a clock that never toggles and hang busy. A write of zero to the event register would clear the done bit if the write-one-to-clear decode were wrong.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W    = 32;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int TOT_BITS   = PRE_BITS + FRAME_W;
  localparam int BIT_CW     = $clog2(TOT_BITS);
  localparam int TA_FIRST   = PRE_BITS + 14;
  localparam int DATA_FIRST = TOT_BITS - DATA_W;
  localparam int REG_AW     = 2;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [REG_AW-1:0] {
    RA_FRAME = 2'd0,
    RA_SPEED = 2'd1,
    RA_EVENT = 2'd2,
    RA_MASK  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SPD_W-1:0] spd,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SPD_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             half_end;

  assign half_end = run && (cnt_q == spd - {{(SPD_W-1){1'b0}}, 1'b1});

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (half_end) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + {{(SPD_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = half_end & ~mdc_q;
  assign fall = half_end &  mdc_q;
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] start_frame,
  input  logic [SPD_W-1:0]   start_spd,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic [SPD_W-1:0]   run_spd,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               done,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_data
);
  logic               busy_q, busy_d;
  logic [BIT_CW-1:0]  bit_q, bit_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               rdop_q, rdop_d;
  logic [SPD_W-1:0]   spd_q, spd_d;
  logic [DATA_W-1:0]  rdsh_q, rdsh_d;
  logic               last_bit;
  logic               in_pre;

  assign last_bit = (bit_q == BIT_CW'(TOT_BITS - 1));
  assign in_pre   = (bit_q < BIT_CW'(PRE_BITS));

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rdop_d = rdop_q;
    spd_d  = spd_q;
    rdsh_d = rdsh_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        bit_d  = '0;
        sh_d   = start_frame;
        rdop_d = (start_frame[29:28] == OP_READ);
        spd_d  = start_spd;
        rdsh_d = '0;
      end
    end else begin
      if (rise && rdop_q && (bit_q >= BIT_CW'(DATA_FIRST)))
        rdsh_d = {rdsh_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (last_bit) busy_d = 1'b0;
        else          bit_d  = bit_q + {{(BIT_CW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rdop_q <= 1'b0;
      spd_q  <= '0;
      rdsh_q <= '0;
    end else begin
      busy_q <= busy_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rdop_q <= rdop_d;
      spd_q  <= spd_d;
      rdsh_q <= rdsh_d;
    end
  end

  assign busy    = busy_q;
  assign run_spd = spd_q;
  assign done    = busy_q && fall && last_bit;
  assign rd_done = done && rdop_q;
  assign rd_data = rdsh_q;
  assign mdio_o  = busy_q && (in_pre ? 1'b1 : sh_q[~bit_q[4:0]]);
  assign mdio_oe = busy_q && !(rdop_q && (bit_q >= BIT_CW'(TA_FIRST)));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  input  logic               busy,
  input  logic               done,
  input  logic               rd_done,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               start,
  output logic [SPD_W-1:0]   spd_reg,
  output logic               event_done,
  output logic               irq
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [SPD_W-1:0]   spd_q, spd_d;
  logic               evt_q, evt_d;
  logic               msk_q, msk_d;
  logic               wr_frame, wr_speed, wr_event, wr_mask;

  assign wr_frame = bus_we && (bus_addr == RA_FRAME);
  assign wr_speed = bus_we && (bus_addr == RA_SPEED);
  assign wr_event = bus_we && (bus_addr == RA_EVENT);
  assign wr_mask  = bus_we && (bus_addr == RA_MASK);
  assign start    = wr_frame && !busy && (spd_q != '0);

  always_comb begin
    frame_d = frame_q;
    spd_d   = spd_q;
    evt_d   = evt_q;
    msk_d   = msk_q;
    if (start)        frame_d = bus_wdata;
    else if (rd_done) frame_d[DATA_W-1:0] = rd_data;
    if (wr_speed)     spd_d = bus_wdata[SPD_W-1:0];
    if (done)                      evt_d = 1'b1;
    else if (wr_event && bus_wdata[0]) evt_d = 1'b0;
    if (wr_mask)      msk_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      spd_q   <= '0;
      evt_q   <= 1'b0;
      msk_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      spd_q   <= spd_d;
      evt_q   <= evt_d;
      msk_q   <= msk_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_FRAME: bus_rdata = frame_q;
      RA_SPEED: bus_rdata = {{(FRAME_W-SPD_W){1'b0}}, spd_q};
      RA_EVENT: bus_rdata = {{(FRAME_W-2){1'b0}}, busy, evt_q};
      RA_MASK:  bus_rdata = {{(FRAME_W-1){1'b0}}, msk_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign spd_reg    = spd_q;
  assign event_done = evt_q;
  assign irq        = evt_q & msk_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  output logic               irq,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic              rst_sync_n;
  logic              start, busy, done, rd_done, rise, fall, event_done;
  logic [SPD_W-1:0]  spd_reg, run_spd;
  logic [DATA_W-1:0] rd_data;

  mdio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mdio_regs #(.SPD_W(SPD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .done       (done),
    .rd_done    (rd_done),
    .rd_data    (rd_data),
    .start      (start),
    .spd_reg    (spd_reg),
    .event_done (event_done),
    .irq        (irq)
  );

  mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (busy),
    .spd   (run_spd),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_engine #(.SPD_W(SPD_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .start_frame (bus_wdata),
    .start_spd   (spd_reg),
    .rise        (rise),
    .fall        (fall),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .run_spd     (run_spd),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .done        (done),
    .rd_done     (rd_done),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int SPD_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             busy,
  input logic [SPD_W-1:0] spd_reg,
  input logic             event_done,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd0 && !busy && spd_reg != '0) |=> busy); // R2

  AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o)); // R3

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> event_done); // R6

  AST_EVENT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2 && bus_wdata[0] && !busy) |=> !event_done); // R7

  AST_NO_START_SPD0: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && spd_reg == '0) |=> !busy); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R11
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.SPD_W(SPD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .spd_reg    (spd_reg),
  .event_done (event_done),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq, mdc, mdio_o, mdio_oe, mdio_i;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  mdio_mgmt_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] wd;
    logic [5:0]  spd;
    logic [15:0] phy;
    logic        msk;
  } vec_t;

  localparam logic [50:0] VECS [4] = '{
    {2'b01, 5'd1,  5'd0,  16'h1140, 6'd2, 16'h0000, 1'b1},
    {2'b10, 5'd31, 5'd2,  16'h0000, 6'd3, 16'hA5C3, 1'b0},
    {2'b10, 5'd0,  5'd31, 16'h0000, 6'd1, 16'h8001, 1'b1},
    {2'b01, 5'd10, 5'd17, 16'hFFFF, 6'd5, 16'h0000, 1'b0}
  };

  // PHY model / monitor state
  bit          mon_en = 0;
  logic        prev_mdc = 1'b0;
  int          bcnt, nrise, ntr, hc, hmin, hmax;
  logic [15:0] phy_word = 16'h0;
  logic        cap_o  [64];
  logic        cap_oe [64];

  always @(negedge clk) begin
    if (mon_en) begin
      if (mdc && !prev_mdc) begin
        if (bcnt < 64) begin
          cap_o[bcnt]  = mdio_o;
          cap_oe[bcnt] = mdio_oe;
        end
        nrise++;
      end
      if (mdc != prev_mdc) begin
        if (ntr > 0) begin
          if (hc < hmin) hmin = hc;
          if (hc > hmax) hmax = hc;
        end
        ntr++;
        hc = 1;
      end else begin
        hc++;
      end
      if (!mdc && prev_mdc) bcnt++;
      mdio_i = (bcnt >= 48 && bcnt < 64) ? phy_word[63-bcnt] : 1'b1;
    end
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic mon_start(input logic [15:0] p);
    bcnt = 0; nrise = 0; ntr = 0; hc = 0; hmin = 9999; hmax = 0;
    phy_word = p;
    mon_en = 1;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int k = 0; k < 5000; k++) begin
      bus_read(2'd2, d);
      if (d[0]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] wd);
    return {2'b01, op, pa, ra, 2'b10, wd};
  endfunction

  task automatic check_stream(input logic [31:0] fr, input bit rd, input string tag);
    bit ok_d = 1, ok_e = 1;
    for (int b = 0; b < 64; b++) begin
      logic exp_o  = (b < 32) ? 1'b1 : fr[63-b];
      logic exp_oe = !(rd && b >= 46);
      if (cap_oe[b] !== exp_oe) ok_e = 0;
      if (exp_oe && cap_o[b] !== exp_o) ok_d = 0;
    end
    check(ok_d, {tag, " R3 stream bits"}, {31'd0, ok_d}, 32'd1);
    check(ok_e, {tag, " R4 enable pattern"}, {31'd0, ok_e}, 32'd1);
  endtask

  initial begin
    logic [31:0] d, fr;
    bit ok;
    vec_t v;
    bus_we = 0; bus_addr = 0; bus_wdata = 0; mdio_i = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check(!mdc && !mdio_oe && !irq, "R1 pins after reset", {29'd0, mdc, mdio_oe, irq}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], d);
      check(d == 32'd0, "R1 register after reset", d, 32'd0);
    end

    // R10 speed zero: frame write starts nothing
    mon_start(16'h0);
    bus_write(2'd0, mk(2'b01, 5'd3, 5'd4, 16'h1234));
    repeat (40) @(posedge clk);
    #1;
    check(ntr == 0, "R10 mdc idle with zero speed", ntr, 0);
    bus_read(2'd2, d);
    check(d[1:0] == 2'b00, "R10 busy stays low", d, 0);
    bus_read(2'd0, d);
    check(d == 32'd0, "R10 frame unchanged", d, 0);
    mon_en = 0;

    // vector table
    for (int i = 0; i < 4; i++) begin
      v = vec_t'(VECS[i]);
      fr = mk(v.op, v.pa, v.ra, v.wd);
      bus_write(2'd1, {26'd0, v.spd});
      bus_write(2'd3, {31'd0, v.msk});
      mon_start(v.phy);
      bus_write(2'd0, fr);
      bus_read(2'd2, d);
      check(d[1] == 1'b1, "R2 busy after start", d, 32'd2);
      wait_done(ok);
      check(ok, "R6 done event set", {31'd0, ok}, 32'd1);
      check(nrise == 64, "R3 64 MDC rising edges", nrise, 64);
      check(hmin == v.spd && hmax == v.spd, "R2 half period equals speed", {hmin[15:0], hmax[15:0]}, {10'd0, v.spd, 10'd0, v.spd});
      check_stream(fr, v.op == 2'b10, "vec");
      bus_read(2'd2, d);
      check(d[1:0] == 2'b01, "R6 busy clear done set", d, 32'd1);
      check(!mdc && !mdio_oe, "R11 idle quiet after end", {30'd0, mdc, mdio_oe}, 0);
      check(irq == v.msk, "R8 irq follows mask", {31'd0, irq}, {31'd0, v.msk});
      bus_read(2'd0, d);
      if (v.op == 2'b10)
        check(d == {fr[31:16], v.phy}, "R5 read data in frame low half", d, {fr[31:16], v.phy});
      else
        check(d == fr, "R5 write frame unchanged", d, fr);
      bus_write(2'd2, 32'd1);
      mon_en = 0;
    end

    // R7 write-one-to-clear
    bus_write(2'd1, 32'd1);
    bus_write(2'd3, 32'd0);
    mon_start(16'h0);
    bus_write(2'd0, mk(2'b01, 5'd2, 5'd9, 16'h00FF));
    wait_done(ok);
    bus_write(2'd2, 32'd0);
    bus_read(2'd2, d);
    check(d[0] == 1'b1, "R7 write zero keeps done", d, 32'd1);
    check(!irq, "R8 masked event sets without irq", {31'd0, irq}, 0);
    bus_write(2'd3, 32'd1);
    #1 check(irq, "R8 irq after enabling mask", {31'd0, irq}, 32'd1);
    bus_write(2'd2, 32'd1);
    bus_read(2'd2, d);
    check(d[0] == 1'b0, "R7 write one clears done", d, 0);
    mon_en = 0;

    // R9 write during busy ignored
    bus_write(2'd1, 32'd2);
    fr = mk(2'b10, 5'd7, 5'd5, 16'h0000);
    mon_start(16'h3C5A);
    bus_write(2'd0, fr);
    repeat (60) @(posedge clk);
    bus_write(2'd0, mk(2'b01, 5'd21, 5'd12, 16'hBEEF));
    wait_done(ok);
    check(ok, "R9 first transaction completes", {31'd0, ok}, 32'd1);
    check_stream(fr, 1'b1, "R9 busy write");
    bus_read(2'd0, d);
    check(d == {fr[31:16], 16'h3C5A}, "R9 frame keeps first value", d, {fr[31:16], 16'h3C5A});
    repeat (20) @(posedge clk);
    bus_read(2'd2, d);
    check(d[1] == 1'b0, "R9 no second transaction", d, 0);
    mon_en = 0;

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule